// File: doc/BRIEF.md
# Upstream Probe Set Timer Buffer

This block keeps one processor's approximate record of the causal upstream set of outstanding invalidation probes in a delayed-consistency coherence scheme. Each probe is a countdown timer. While a probe's timer is still running, stale data guarded by it may still be used. When the timer reaches zero, the probe has expired and its slot is freed with no explicit removal. The block has three interfaces. It creates a local probe when the node sends an invalidation for a write miss. It folds in the probe set carried by an arriving invalidation acknowledgment. It presents the current set, one timer per processor, so the node can attach that set to the acknowledgments it sends.

Storage is a small physical buffer of probe slots. A probe the node creates itself is named by a virtual identifier: the request address, hashed into a 256-entry namespace. An index table maps that identifier to a physical slot, so that a repeat invalidation for the same identifier refreshes the existing probe instead of taking a new slot. A merged probe is keyed by the processor it belongs to. When every slot is live, a new probe displaces the one closest to expiry.

Both request ports use valid/ready. A transfer happens on a rising clock edge where valid and ready are both high. A sender that sees ready low must hold valid and its data stable until the transfer. A merge occupies the block for one cycle per processor, and during that time both ready outputs are low. A merge offer also holds off a create offered in the same cycle. The set output and the tick input are plain signals with no handshake.

Top module: `upstream_probe_buf`

## Requirements
- R1: After reset, every timer is zero, `set_o` is all zeros, and `cr_ready_o` and `mg_ready_o` are both high.
- R2: A create is accepted on a rising edge where `cr_valid_i` and `cr_ready_o` are both high. From the next cycle, field SELF_ID of `set_o` equals 2^TW-1.
- R3: The virtual identifier of a create is the XOR of the 8-bit chunks of `cr_addr_i`. A create whose identifier matches a live local probe reloads that probe to 2^TW-1 and takes no new slot, even when the buffer is full.
- R4: On each cycle with `tick_i` high, every live timer decrements by one, except a timer written in that cycle. A timer that reaches zero frees its slot and leaves the set. When `tick_i` is low, timers hold their values.
- R5: Field k of `set_o` is bits [k*TW +: TW]. It equals the largest remaining timer among live probes owned by processor k, or zero if processor k owns no live probe. Local probes are owned by SELF_ID.
- R6: A merge is accepted on a rising edge where `mg_valid_i` and `mg_ready_o` are both high. Field k of `mg_set_i` (same bit positions as `set_o`) is applied at the (k+1)-th rising edge after acceptance. Both ready outputs stay low for NPROC cycles after acceptance.
- R7: A nonzero incoming field k updates the merged probe of processor k. If that probe is live, it keeps the larger of its current count and the incoming count. If it is not live, a new probe is inserted with the incoming count. An incoming field of zero changes nothing.
- R8: When all PHYS slots are live, a new probe (create or merge) replaces the live probe with the smallest remaining count. Ties go to the lowest slot.
- R9: While idle, `mg_valid_i` high forces `cr_ready_o` low, so a merge wins over a create offered in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Decrements every live timer by one |
| cr_valid_i | input | 1 | Create request valid |
| cr_ready_o | output | 1 | Create request ready |
| cr_addr_i | input | ADDR_W | Address of the line being invalidated |
| mg_valid_i | input | 1 | Incoming probe set valid |
| mg_ready_o | output | 1 | Incoming probe set ready |
| mg_set_i | input | NPROC*TW | Incoming probe set, one timer per processor |
| set_o | output | NPROC*TW | Current upstream set, one timer per processor |

## Verification
Most faults in the slot state show up at `set_o` in the cycle after they occur. A lost or misrouted write, a wrong decrement, or a slot that is freed by mistake changes the maximum reported for some processor. The exception is a slot that is not the current maximum for its owner. Such a fault stays hidden until that slot becomes the maximum, or until it changes which slot is chosen for eviction. The eviction and alias tests are built so that this choice becomes visible: a probe of another processor disappears from the set, or stays in it, at a known cycle. A cycle-accurate reference model is compared against `set_o` and both ready outputs on every clock, so a fault is reported in the first cycle it reaches a port.

// File: rtl/ups_pkg.sv
package ups_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_CREATE = 2'd1,
    OP_MERGE  = 2'd2
  } op_e;
endpackage

// File: rtl/ups_index_table.sv
module ups_index_table #(
  parameter int VIRT = 256,
  parameter int PHYS = 32,
  localparam int VW = $clog2(VIRT),
  localparam int SW = $clog2(PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] rd_vid,
  output logic [SW-1:0] rd_slot,
  input  logic          wr_en,
  input  logic [VW-1:0] wr_vid,
  input  logic [SW-1:0] wr_slot
);
  // A stale mapping is harmless: the reader confirms it against the slot's own tag.
  logic [SW-1:0] map_q [VIRT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < VIRT; i++) map_q[i] <= '0;
    end else if (wr_en) begin
      map_q[wr_vid] <= wr_slot;
    end
  end

  assign rd_slot = map_q[rd_vid];
endmodule

// File: rtl/ups_slot_bank.sv
module ups_slot_bank #(
  parameter int PHYS  = 32,
  parameter int TW    = 14,
  parameter int PW    = 2,
  parameter int VW    = 8,
  localparam int SW = $clog2(PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_slot,
  input  logic [TW-1:0] wr_tmr,
  input  logic [PW-1:0] wr_own,
  input  logic          wr_loc,
  input  logic [VW-1:0] wr_vid,
  output logic [TW-1:0] tmr_o [PHYS],
  output logic [PW-1:0] own_o [PHYS],
  output logic          loc_o [PHYS],
  output logic [VW-1:0] vid_o [PHYS]
);
  for (genvar s = 0; s < PHYS; s++) begin : g_slot
    logic [TW-1:0] t_q;
    logic [PW-1:0] o_q;
    logic          l_q;
    logic [VW-1:0] v_q;
    logic          hit;

    assign hit = wr_en && (wr_slot == SW'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        t_q <= '0;
        o_q <= '0;
        l_q <= 1'b0;
        v_q <= '0;
      end else if (hit) begin
        t_q <= wr_tmr;
        o_q <= wr_own;
        l_q <= wr_loc;
        v_q <= wr_vid;
      end else if (tick && (t_q != '0)) begin
        t_q <= t_q - 1'b1;
      end
    end

    assign tmr_o[s] = t_q;
    assign own_o[s] = o_q;
    assign loc_o[s] = l_q;
    assign vid_o[s] = v_q;
  end
endmodule

// File: rtl/ups_victim_pick.sv
module ups_victim_pick #(
  parameter int PHYS = 32,
  parameter int TW   = 14,
  localparam int SW = $clog2(PHYS)
) (
  input  logic [TW-1:0] tmr   [PHYS],
  output logic          free_hit,
  output logic [SW-1:0] free_slot,
  output logic [SW-1:0] min_slot
);
  logic [TW-1:0] min_val;

  always_comb begin
    free_hit  = 1'b0;
    free_slot = '0;
    for (int s = 0; s < PHYS; s++) begin
      if (!free_hit && (tmr[s] == '0)) begin
        free_hit  = 1'b1;
        free_slot = SW'(s);
      end
    end
  end

  always_comb begin
    min_val  = tmr[0];
    min_slot = '0;
    for (int s = 1; s < PHYS; s++) begin
      if (tmr[s] < min_val) begin
        min_val  = tmr[s];
        min_slot = SW'(s);
      end
    end
  end
endmodule

// File: rtl/ups_set_reduce.sv
module ups_set_reduce #(
  parameter int PHYS  = 32,
  parameter int NPROC = 4,
  parameter int TW    = 14,
  parameter int PW    = 2
) (
  input  logic [TW-1:0]       tmr [PHYS],
  input  logic [PW-1:0]       own [PHYS],
  output logic [NPROC*TW-1:0] set_o
);
  for (genvar k = 0; k < NPROC; k++) begin : g_proc
    logic [TW-1:0] best;
    always_comb begin
      best = '0;
      for (int s = 0; s < PHYS; s++) begin
        if ((own[s] == PW'(k)) && (tmr[s] > best)) best = tmr[s];
      end
    end
    assign set_o[k*TW +: TW] = best;
  end
endmodule

// File: rtl/upstream_probe_buf.sv
module upstream_probe_buf #(
  parameter int NPROC   = 4,
  parameter int TW      = 14,
  parameter int PHYS    = 32,
  parameter int VIRT    = 256,
  parameter int ADDR_W  = 32,
  parameter int SELF_ID = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                cr_valid_i,
  output logic                cr_ready_o,
  input  logic [ADDR_W-1:0]   cr_addr_i,
  input  logic                mg_valid_i,
  output logic                mg_ready_o,
  input  logic [NPROC*TW-1:0] mg_set_i,
  output logic [NPROC*TW-1:0] set_o
);
  import ups_pkg::*;

  localparam int PW     = (NPROC > 1) ? $clog2(NPROC) : 1;
  localparam int SW     = $clog2(PHYS);
  localparam int VW     = $clog2(VIRT);
  localparam int NCHUNK = (ADDR_W + VW - 1) / VW;
  localparam logic [TW-1:0] TMAX = '1;

  // merge sequencer
  logic                busy_q;
  logic [PW-1:0]       step_q;
  logic [NPROC*TW-1:0] mset_q;

  assign mg_ready_o = !busy_q;
  assign cr_ready_o = !busy_q && !mg_valid_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
      mset_q <= '0;
    end else if (busy_q) begin
      if (step_q == PW'(NPROC - 1)) begin
        busy_q <= 1'b0;
        step_q <= '0;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end else if (mg_valid_i) begin
      busy_q <= 1'b1;
      step_q <= '0;
      mset_q <= mg_set_i;
    end
  end

  op_e op;
  always_comb begin
    if (busy_q)                        op = OP_MERGE;
    else if (cr_valid_i && cr_ready_o) op = OP_CREATE;
    else                               op = OP_IDLE;
  end

  // address fold into the virtual namespace
  logic [NCHUNK*VW-1:0] addr_ext;
  logic [VW-1:0]        vid;
  assign addr_ext = (NCHUNK*VW)'(cr_addr_i);
  always_comb begin
    vid = '0;
    for (int c = 0; c < NCHUNK; c++) vid = vid ^ addr_ext[c*VW +: VW];
  end

  // slot state
  logic [TW-1:0] tmr [PHYS];
  logic [PW-1:0] own [PHYS];
  logic          loc [PHYS];
  logic [VW-1:0] svid [PHYS];

  logic          wr_en;
  logic [SW-1:0] wr_slot;
  logic [TW-1:0] wr_tmr;
  logic [PW-1:0] wr_own;
  logic          wr_loc;
  logic [VW-1:0] wr_vid;
  logic          ix_we;
  logic [SW-1:0] ix_slot;

  ups_index_table #(.VIRT(VIRT), .PHYS(PHYS)) u_index (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_vid  (vid),
    .rd_slot (ix_slot),
    .wr_en   (ix_we),
    .wr_vid  (vid),
    .wr_slot (wr_slot)
  );

  ups_slot_bank #(.PHYS(PHYS), .TW(TW), .PW(PW), .VW(VW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_i),
    .wr_en   (wr_en),
    .wr_slot (wr_slot),
    .wr_tmr  (wr_tmr),
    .wr_own  (wr_own),
    .wr_loc  (wr_loc),
    .wr_vid  (wr_vid),
    .tmr_o   (tmr),
    .own_o   (own),
    .loc_o   (loc),
    .vid_o   (svid)
  );

  logic          free_hit;
  logic [SW-1:0] free_slot;
  logic [SW-1:0] min_slot;
  logic [SW-1:0] alloc_slot;

  ups_victim_pick #(.PHYS(PHYS), .TW(TW)) u_victim (
    .tmr       (tmr),
    .free_hit  (free_hit),
    .free_slot (free_slot),
    .min_slot  (min_slot)
  );

  assign alloc_slot = free_hit ? free_slot : min_slot;

  ups_set_reduce #(.PHYS(PHYS), .NPROC(NPROC), .TW(TW), .PW(PW)) u_reduce (
    .tmr   (tmr),
    .own   (own),
    .set_o (set_o)
  );

  // local probe lookup through the index table, confirmed by the slot tag
  logic lhit;
  assign lhit = (tmr[ix_slot] != '0) && loc[ix_slot] && (svid[ix_slot] == vid);

  // merged probe lookup by owner
  logic [TW-1:0] mfield;
  logic          mhit;
  logic [SW-1:0] mslot;
  assign mfield = mset_q[int'(step_q)*TW +: TW];
  always_comb begin
    mhit  = 1'b0;
    mslot = '0;
    for (int s = 0; s < PHYS; s++) begin
      if (!mhit && (tmr[s] != '0) && !loc[s] && (own[s] == step_q)) begin
        mhit  = 1'b1;
        mslot = SW'(s);
      end
    end
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_slot = alloc_slot;
    wr_tmr  = TMAX;
    wr_own  = PW'(SELF_ID);
    wr_loc  = 1'b1;
    wr_vid  = vid;
    ix_we   = 1'b0;
    case (op)
      OP_CREATE: begin
        wr_en = 1'b1;
        if (lhit) wr_slot = ix_slot;
        else      ix_we   = 1'b1;
      end
      OP_MERGE: begin
        if (mfield != '0) begin
          wr_en  = 1'b1;
          wr_own = step_q;
          wr_loc = 1'b0;
          wr_vid = '0;
          if (mhit) begin
            wr_slot = mslot;
            wr_tmr  = (tmr[mslot] > mfield) ? tmr[mslot] : mfield;
          end else begin
            wr_tmr  = mfield;
          end
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ups_checker.sv
module ups_checker #(
  parameter int NPROC   = 4,
  parameter int TW      = 14,
  parameter int SELF_ID = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick_i,
  input logic                cr_valid_i,
  input logic                cr_ready_o,
  input logic                mg_valid_i,
  input logic                mg_ready_o,
  input logic [NPROC*TW-1:0] set_o
);
  localparam logic [TW-1:0] TMAX = '1;

  logic quiet;
  assign quiet = mg_ready_o && !mg_valid_i && !(cr_valid_i && cr_ready_o);

  assert_merge_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mg_valid_i |-> !cr_ready_o);

  assert_merge_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mg_valid_i && mg_ready_o) |=> (!mg_ready_o && !cr_ready_o));

  assert_create_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_valid_i && cr_ready_o) |=> (set_o[SELF_ID*TW +: TW] == TMAX));

  for (genvar k = 0; k < NPROC; k++) begin : g_field
    assert_tick_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet && tick_i) |=> (set_o[k*TW +: TW] ==
        (($past(set_o[k*TW +: TW]) == '0) ? '0 : $past(set_o[k*TW +: TW]) - 1'b1)));

    assert_tick_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet && !tick_i) |=> $stable(set_o[k*TW +: TW]));
  end
endmodule

bind upstream_probe_buf ups_checker #(.NPROC(NPROC), .TW(TW), .SELF_ID(SELF_ID)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_i     (tick_i),
  .cr_valid_i (cr_valid_i),
  .cr_ready_o (cr_ready_o),
  .mg_valid_i (mg_valid_i),
  .mg_ready_o (mg_ready_o),
  .set_o      (set_o)
);

// File: tb/upstream_probe_buf_test.sv
module upstream_probe_buf_test;
  localparam int NPROC = 4, TW = 14, PHYS = 32, VIRT = 256, ADDR_W = 32, SELF_ID = 1;
  localparam int TMAX = (1 << TW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic cr_valid = 1'b0, mg_valid = 1'b0;
  logic [ADDR_W-1:0] cr_addr = '0;
  logic [NPROC*TW-1:0] mg_set = '0;
  logic cr_ready, mg_ready;
  logic [NPROC*TW-1:0] set_o;

  upstream_probe_buf #(.NPROC(NPROC), .TW(TW), .PHYS(PHYS), .VIRT(VIRT),
                       .ADDR_W(ADDR_W), .SELF_ID(SELF_ID)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .cr_valid_i(cr_valid), .cr_ready_o(cr_ready), .cr_addr_i(cr_addr),
    .mg_valid_i(mg_valid), .mg_ready_o(mg_ready), .mg_set_i(mg_set),
    .set_o(set_o));

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reference model
  typedef struct { int owner; bit loc; int vid; int t; } rec_t;
  rec_t q[$];
  bit   m_busy = 0;
  int   m_step = 0;
  int   mset[NPROC];

  function automatic int mhash(logic [ADDR_W-1:0] a);
    int h = 0;
    for (int c = 0; c < ADDR_W / 8; c++) h = h ^ int'(a[c*8 +: 8]);
    return h;
  endfunction

  function automatic int mmax(int k);
    int b = 0;
    foreach (q[i]) if (q[i].owner == k && q[i].t > b) b = q[i].t;
    return b;
  endfunction

  function automatic int m_alloc(int o, bit l, int v);
    rec_t r;
    int mi = 0;
    r.owner = o; r.loc = l; r.vid = v; r.t = 0;
    if (q.size() < PHYS) begin
      q.push_back(r);
      return q.size() - 1;
    end
    foreach (q[i]) if (q[i].t < q[mi].t) mi = i;
    q[mi] = r;
    return mi;
  endfunction

  always @(posedge clk) begin : mdl
    int tgt, nv, t, h;
    tgt = -1; nv = 0;
    if (!rst_n) begin
      q.delete(); m_busy = 0; m_step = 0;
    end else begin
      if (m_busy) begin
        t = mset[m_step];
        if (t != 0) begin
          foreach (q[i]) if (q[i].owner == m_step && !q[i].loc) tgt = i;
          if (tgt >= 0) nv = (q[tgt].t > t) ? q[tgt].t : t;
          else begin tgt = m_alloc(m_step, 0, 0); nv = t; end
        end
        m_step++;
        if (m_step == NPROC) begin m_busy = 0; m_step = 0; end
      end else if (mg_valid) begin
        for (int k = 0; k < NPROC; k++) mset[k] = int'(mg_set[k*TW +: TW]);
        m_busy = 1; m_step = 0;
      end else if (cr_valid) begin
        h = mhash(cr_addr);
        foreach (q[i]) if (q[i].loc && q[i].vid == h) tgt = i;
        if (tgt < 0) tgt = m_alloc(SELF_ID, 1, h);
        nv = TMAX;
      end
      if (tick) foreach (q[i]) if (i != tgt && q[i].t > 0) q[i].t--;
      if (tgt >= 0) q[tgt].t = nv;
      for (int i = q.size() - 1; i >= 0; i--) if (q[i].t == 0) q.delete(i);
    end
    #5;
    if (rst_n && !done) begin
      for (int k = 0; k < NPROC; k++)
        check(set_o[k*TW +: TW] == mmax(k), "R5 set field", set_o[k*TW +: TW], mmax(k));
      check(mg_ready == !m_busy, "R6 merge ready", mg_ready, !m_busy);
      check(cr_ready == (!m_busy && !mg_valid), "R9 create ready", cr_ready, !m_busy && !mg_valid);
    end
  end

  function automatic int fld(int k);
    return int'(set_o[k*TW +: TW]);
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0; tick = 0; cr_valid = 0; mg_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic do_create(logic [ADDR_W-1:0] a);
    @(negedge clk); cr_valid = 1; cr_addr = a; #1;
    while (!cr_ready) begin @(negedge clk); #1; end
    @(negedge clk); cr_valid = 0;
  endtask

  task automatic do_merge(int f0, int f1, int f2, int f3);
    @(negedge clk); mg_valid = 1;
    mg_set = {TW'(f3), TW'(f2), TW'(f1), TW'(f0)}; #1;
    while (!mg_ready) begin @(negedge clk); #1; end
    @(negedge clk); mg_valid = 0; #1;
    check(!mg_ready && !cr_ready, "R6 busy after accept", mg_ready, 0);
    for (int i = 1; i < NPROC; i++) begin
      @(negedge clk); #1;
      check(!mg_ready, "R6 busy window", mg_ready, 0);
    end
    @(negedge clk); #1;
    check(mg_ready, "R6 ready after window", mg_ready, 1);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    // R1
    check(set_o == '0, "R1 set after reset", set_o, 0);
    check(cr_ready && mg_ready, "R1 ready after reset", {cr_ready, mg_ready}, 3);

    // R7 with tick held low
    do_merge(100, 0, 0, 0);
    check(fld(0) == 100, "R7 new merged probe", fld(0), 100);
    check(fld(1) == 0, "R7 zero field ignored", fld(1), 0);
    do_merge(30, 0, 0, 0);
    check(fld(0) == 100, "R7 smaller merge keeps larger", fld(0), 100);
    do_merge(250, 0, 7, 0);
    check(fld(0) == 250, "R7 larger merge raises", fld(0), 250);
    check(fld(2) == 7, "R7 second processor", fld(2), 7);

    // R4 hold and countdown
    repeat (5) @(negedge clk);
    check(fld(0) == 250, "R4 hold without tick", fld(0), 250);
    tick = 1;
    repeat (7) @(negedge clk);
    #1;
    check(fld(2) == 0, "R4 expired probe leaves set", fld(2), 0);
    check(fld(0) == 243, "R4 countdown", fld(0), 243);

    // R2 create
    do_create(32'h0000_0040);
    #1;
    check(fld(SELF_ID) > TMAX - 3, "R2 create loads full count", fld(SELF_ID), TMAX);

    // R9 merge wins
    @(negedge clk); mg_valid = 1; cr_valid = 1; cr_addr = 32'h77; mg_set = '0; #1;
    check(!cr_ready, "R9 create held off", cr_ready, 0);
    @(negedge clk); mg_valid = 0; cr_valid = 0;
    repeat (NPROC + 2) @(negedge clk);

    // R3 and R8 on a full buffer
    do_reset();
    tick = 1;
    do_merge(0, 0, 0, 600);
    for (int i = 0; i < PHYS - 1; i++) do_create(ADDR_W'(32'h20 + i));
    #1;
    check(fld(3) > 0, "R8 probe live before fill", fld(3), 1);
    do_create(32'h0100_0021); // folds to 0x20, aliases the first create
    #1;
    check(fld(3) > 0, "R3 alias takes no slot", fld(3), 1);
    do_create(32'h0000_0050);
    #1;
    check(fld(3) == 0, "R8 smallest probe evicted", fld(3), 0);
    do_create(32'h0000_0051);
    do_merge(0, 0, 9, 0);
    #1;
    check(fld(2) > 0, "R8 merged insert on full buffer", fld(2), 1);
    repeat (20) @(negedge clk);
    #1;
    check(fld(2) == 0, "R4 merged probe expires", fld(2), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule